// File: doc/BRIEF.md
# Transceiver PLL Line-Rate Change Sequencer

This block moves a serial link from one line rate to another without a reload of the device. On a start request it selects a rate and walks a small built-in settings table. For each table entry it updates one configuration register of each quad PLL over that PLL's reconfiguration port. Every update is a read, then a merge of the new bits under a mask, then a write, and then an optional read-back to confirm the result. Other attributes that share the same register are left as they were.

All PLL instances that feed the link are programmed first, one after the other. Only then does the block raise a single combined PLL-and-datapath reset. It holds that reset for a programmable number of cycles, releases it, and waits until every PLL reports lock in the same cycle. Success is a one-cycle done pulse. A bad rate code, a port that never answers, a read-back mismatch or a missing lock ends the sequence with a one-cycle error pulse.

Top module: `pll_rate_sequencer`

## Requirements
- R1: Out of reset, busy_o, done_o, error_o, pll_rst_o and every port enable are low.
- R2: Each register update changes only the bits selected by the entry mask. All other bits of that register keep the value read just before the write.
- R3: Rate codes 0, 1, 2, 3 and 4 select 4, 6, 8, 10 and 12 Gb/s. The feedback divider field, bits [7:0] of address 0x094, becomes 0x14, 0x1E, 0x28, 0x32 or 0x3C for those codes.
- R4: Every rate sets bits [6:5] of address 0x098 to 2'b10, so a register that holds 0x0820 ends at 0x0840.
- R5: All table writes go to PLL 0 before any go to PLL 1 and onward, and every write of every PLL is complete before pll_rst_o rises (3 writes per PLL).
- R6: pll_rst_o is high for exactly RESET_HOLD_CYC consecutive cycles per sequence, and no port access happens while it is high.
- R7: done_o is a one-cycle pulse in the cycle after all lock_i bits are seen high together. It never coincides with error_o.
- R8: The output divider field, bits [10:8] of address 0x0A0, is set to 1 for rate codes 0 and 1 and to 0 for codes 2 to 4. The table entry after it is a terminator (mask zero) that ends the list for that PLL.
- R9: A start request while busy_o is high is ignored: the running sequence completes with its own rate and only one result pulse.
- R10: A start with a rate code of 5, 6 or 7 gives an error_o pulse in the next cycle and makes no port access.
- R11: If the lock AND is not seen within LOCK_TIMEOUT_CYC cycles after the reset is released, error_o pulses and done_o does not.
- R12: If a port does not return ready within ACK_TIMEOUT_CYC cycles of its enable, error_o pulses and no further request is issued.
- R13: With VERIFY_EN set, each write is read back. A value that differs from the merged value gives an error_o pulse.
- R14: At most one port enable is high in a cycle, and no new enable is issued while an access is still waiting for ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request a rate change (taken only when idle) |
| rate_i | input | 3 | Rate code sampled with start_i |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle success pulse |
| error_o | output | 1 | One-cycle failure pulse |
| port_en_o | output | NUM_PLL | Per-PLL access enable |
| port_we_o | output | NUM_PLL | Per-PLL write enable |
| port_addr_o | output | NUM_PLL*9 | Per-PLL register address |
| port_wdata_o | output | NUM_PLL*16 | Per-PLL write data |
| port_rdata_i | input | NUM_PLL*16 | Per-PLL read data |
| port_rdy_i | input | NUM_PLL | Per-PLL access ready |
| pll_rst_o | output | 1 | Combined PLL-and-datapath reset |
| lock_i | input | NUM_PLL | Per-PLL lock indication |

## Verification
The results arrive at these times after their stimulus:
- A port enable appears one cycle after the sequencer asks for an access.
- done_o appears one cycle after the first cycle in which every lock bit is high.
- A bad rate code gives error_o one cycle after the start.
- pll_rst_o stays high for exactly the hold count.

The bench pushes the expected outcome of each sequence into a queue before it pulses start. A monitor samples on the falling clock edge, pops one item per result pulse and compares it. Register contents are compared only after busy_o has dropped. The reset width and the write count at reset rise are measured cycle by cycle by the same monitor.

// File: rtl/rsq_pkg.sv
// Shared types and the per-rate settings table of the rate-change sequencer.
// Assumes 9-bit register addresses and 16-bit register data on each PLL port.
package rsq_pkg;

    localparam int CFG_ADDR_W  = 9;
    localparam int CFG_DATA_W  = 16;
    localparam int RATE_W      = 3;
    localparam int NUM_RATES   = 5;
    localparam int ENTRY_IDX_W = 2;

    typedef struct packed {
        logic [CFG_ADDR_W-1:0] addr;
        logic [CFG_DATA_W-1:0] mask;
        logic [CFG_DATA_W-1:0] value;
    } cfg_entry_t;

    typedef enum logic [3:0] {
        S_IDLE, S_FETCH, S_RD_REQ, S_RD_WAIT, S_WR_REQ, S_WR_WAIT,
        S_VR_REQ, S_VR_WAIT, S_RST_HOLD, S_LOCK_WAIT, S_DONE, S_FAIL
    } seq_state_t;

    // Table entry idx for a rate code; a zero mask marks the end of the list.
    function automatic cfg_entry_t rate_entry(input logic [RATE_W-1:0] rate,
                                              input logic [ENTRY_IDX_W-1:0] idx);
        cfg_entry_t e;
        int n_div;
        n_div = 20 + 10 * int'(rate);
        case (idx)
            2'd0:    e = '{addr: 9'h094, mask: 16'h00FF, value: 16'(n_div)};
            2'd1:    e = '{addr: 9'h098, mask: 16'h0060, value: 16'h0040};
            2'd2:    e = '{addr: 9'h0A0, mask: 16'h0700,
                           value: (rate < 3'd2) ? 16'h0100 : 16'h0000};
            default: e = '{addr: '0, mask: '0, value: '0};
        endcase
        return e;
    endfunction

endpackage

// File: rtl/rsq_rate_table.sv
// Settings lookup: gives the (address, mask, value) entry for the active
// rate and entry index, and judges whether a requested rate code exists.
// Assumes rate_i is a code already latched by the caller; pure logic.
module rsq_rate_table
    import rsq_pkg::*;
(
    input  logic [RATE_W-1:0]      rate_i,
    input  logic [ENTRY_IDX_W-1:0] idx_i,
    input  logic [RATE_W-1:0]      req_rate_i,
    output cfg_entry_t             entry_o,
    output logic                   end_o,
    output logic                   req_ok_o
);

    // Entry lookup and terminator/rate-range decode.
    always_comb begin
        entry_o  = rate_entry(rate_i, idx_i);
        end_o    = (entry_o.mask == '0);
        req_ok_o = (int'(req_rate_i) < NUM_RATES);
    end

endmodule

// File: rtl/rsq_port_engine.sv
// Single-access engine for the per-PLL reconfiguration ports. It raises the
// enable of one selected PLL for one cycle, waits for that PLL's ready, and
// returns the read data or a timeout pulse after ACK_TIMEOUT_CYC cycles.
// Assumes the caller issues req_i only when no access is in flight.
module rsq_port_engine
    import rsq_pkg::*;
#(
    parameter int NUM_PLL         = 2,
    parameter int ACK_TIMEOUT_CYC = 1024,
    localparam int SEL_W = (NUM_PLL > 1) ? $clog2(NUM_PLL) : 1,
    localparam int WD_W  = $clog2(ACK_TIMEOUT_CYC + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_i,
    input  logic                           we_i,
    input  logic [SEL_W-1:0]               sel_i,
    input  logic [CFG_ADDR_W-1:0]          addr_i,
    input  logic [CFG_DATA_W-1:0]          wdata_i,
    output logic                           done_o,
    output logic                           timeout_o,
    output logic [CFG_DATA_W-1:0]          rdata_o,
    output logic [NUM_PLL-1:0]             port_en_o,
    output logic [NUM_PLL-1:0]             port_we_o,
    output logic [NUM_PLL*CFG_ADDR_W-1:0]  port_addr_o,
    output logic [NUM_PLL*CFG_DATA_W-1:0]  port_wdata_o,
    input  logic [NUM_PLL*CFG_DATA_W-1:0]  port_rdata_i,
    input  logic [NUM_PLL-1:0]             port_rdy_i
);

    logic                  busy_q, en_q, we_q, done_q, timeout_q;
    logic [SEL_W-1:0]      sel_q;
    logic [CFG_ADDR_W-1:0] addr_q;
    logic [CFG_DATA_W-1:0] wdata_q, rdata_q;
    logic [WD_W-1:0]       wd_cnt_q;

    // Access launch, ready wait, read capture and watchdog.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            en_q      <= 1'b0;
            we_q      <= 1'b0;
            done_q    <= 1'b0;
            timeout_q <= 1'b0;
            sel_q     <= '0;
            addr_q    <= '0;
            wdata_q   <= '0;
            rdata_q   <= '0;
            wd_cnt_q  <= '0;
        end else begin
            en_q      <= 1'b0;
            done_q    <= 1'b0;
            timeout_q <= 1'b0;
            if (req_i && !busy_q) begin
                busy_q   <= 1'b1;
                en_q     <= 1'b1;
                we_q     <= we_i;
                sel_q    <= sel_i;
                addr_q   <= addr_i;
                wdata_q  <= wdata_i;
                wd_cnt_q <= '0;
            end else if (busy_q) begin
                if (port_rdy_i[sel_q]) begin
                    busy_q  <= 1'b0;
                    done_q  <= 1'b1;
                    rdata_q <= port_rdata_i[int'(sel_q)*CFG_DATA_W +: CFG_DATA_W];
                end else if (wd_cnt_q == WD_W'(ACK_TIMEOUT_CYC - 1)) begin
                    busy_q    <= 1'b0;
                    timeout_q <= 1'b1;
                end else begin
                    wd_cnt_q <= wd_cnt_q + 1'b1;
                end
            end
        end
    end

    assign done_o    = done_q;
    assign timeout_o = timeout_q;
    assign rdata_o   = rdata_q;

    // Per-PLL port fan-out: address and data are shared, enables are selected.
    for (genvar g = 0; g < NUM_PLL; g++) begin : g_port
        assign port_en_o[g] = en_q && (sel_q == SEL_W'(g));
        assign port_we_o[g] = en_q && we_q && (sel_q == SEL_W'(g));
        assign port_addr_o[g*CFG_ADDR_W +: CFG_ADDR_W]  = addr_q;
        assign port_wdata_o[g*CFG_DATA_W +: CFG_DATA_W] = wdata_q;
    end

endmodule

// File: rtl/rsq_timer.sv
// Down-counting interval timer. A load of N makes expired_o rise N-1 cycles
// after the load edge, i.e. the waiting state lasts exactly N cycles.
// Assumes load_val_i is at least 1.
module rsq_timer #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);

    logic             armed_q;
    logic [CNT_W-1:0] cnt_q;

    // Load or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else if (load_i) begin
            armed_q <= 1'b1;
            cnt_q   <= load_val_i - 1'b1;
        end else if (armed_q && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = armed_q && (cnt_q == '0);

endmodule

// File: rtl/pll_rate_sequencer.sv
// Line-rate change sequencer. It programs every PLL through masked
// read-modify-write (with optional read-back), pulses one shared
// PLL-and-datapath reset, and then waits for the AND of all locks.
// Assumes lock_i and port_rdy_i are synchronous to clk.
module pll_rate_sequencer
    import rsq_pkg::*;
#(
    parameter int NUM_PLL          = 2,
    parameter int RESET_HOLD_CYC   = 2000000,
    parameter int LOCK_TIMEOUT_CYC = 5000000,
    parameter int ACK_TIMEOUT_CYC  = 1024,
    parameter bit VERIFY_EN        = 1'b1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start_i,
    input  logic [2:0]                     rate_i,
    output logic                           busy_o,
    output logic                           done_o,
    output logic                           error_o,
    output logic [NUM_PLL-1:0]             port_en_o,
    output logic [NUM_PLL-1:0]             port_we_o,
    output logic [NUM_PLL*9-1:0]           port_addr_o,
    output logic [NUM_PLL*16-1:0]          port_wdata_o,
    input  logic [NUM_PLL*16-1:0]          port_rdata_i,
    input  logic [NUM_PLL-1:0]             port_rdy_i,
    output logic                           pll_rst_o,
    input  logic [NUM_PLL-1:0]             lock_i
);

    localparam int SEL_W = (NUM_PLL > 1) ? $clog2(NUM_PLL) : 1;
    localparam int TMR_W = 32;

    seq_state_t             state_q;
    logic [RATE_W-1:0]      rate_q;
    logic [SEL_W-1:0]       pll_q;
    logic [ENTRY_IDX_W-1:0] idx_q;
    logic [CFG_DATA_W-1:0]  want_q;

    cfg_entry_t             entry;
    logic                   entry_end, req_rate_ok;
    logic                   eng_req, eng_we, eng_done, eng_timeout;
    logic [CFG_DATA_W-1:0]  eng_rdata;
    logic                   tmr_load, tmr_expired;
    logic [TMR_W-1:0]       tmr_val;
    logic                   last_pll;

    rsq_rate_table u_table (
        .rate_i     (rate_q),
        .idx_i      (idx_q),
        .req_rate_i (rate_i),
        .entry_o    (entry),
        .end_o      (entry_end),
        .req_ok_o   (req_rate_ok)
    );

    rsq_port_engine #(
        .NUM_PLL         (NUM_PLL),
        .ACK_TIMEOUT_CYC (ACK_TIMEOUT_CYC)
    ) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (eng_req),
        .we_i         (eng_we),
        .sel_i        (pll_q),
        .addr_i       (entry.addr),
        .wdata_i      (want_q),
        .done_o       (eng_done),
        .timeout_o    (eng_timeout),
        .rdata_o      (eng_rdata),
        .port_en_o    (port_en_o),
        .port_we_o    (port_we_o),
        .port_addr_o  (port_addr_o),
        .port_wdata_o (port_wdata_o),
        .port_rdata_i (port_rdata_i),
        .port_rdy_i   (port_rdy_i)
    );

    rsq_timer #(.CNT_W(TMR_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_expired)
    );

    assign last_pll = (pll_q == SEL_W'(NUM_PLL - 1));

    // Access requests and timer loads decoded from the current state.
    always_comb begin
        eng_req  = (state_q == S_RD_REQ) || (state_q == S_WR_REQ) || (state_q == S_VR_REQ);
        eng_we   = (state_q == S_WR_REQ);
        tmr_load = 1'b0;
        tmr_val  = TMR_W'(RESET_HOLD_CYC);
        if (state_q == S_FETCH && entry_end && last_pll) begin
            tmr_load = 1'b1;
        end else if (state_q == S_RST_HOLD && tmr_expired) begin
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(LOCK_TIMEOUT_CYC);
        end
    end

    // Main sequence: table walk per PLL, shared reset, lock wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            rate_q  <= '0;
            pll_q   <= '0;
            idx_q   <= '0;
            want_q  <= '0;
        end else begin
            case (state_q)
                S_IDLE: if (start_i) begin
                    if (req_rate_ok) begin
                        rate_q  <= rate_i;
                        pll_q   <= '0;
                        idx_q   <= '0;
                        state_q <= S_FETCH;
                    end else begin
                        state_q <= S_FAIL;
                    end
                end
                S_FETCH: begin
                    if (!entry_end) begin
                        state_q <= S_RD_REQ;
                    end else if (last_pll) begin
                        state_q <= S_RST_HOLD;
                    end else begin
                        pll_q <= pll_q + 1'b1;
                        idx_q <= '0;
                    end
                end
                S_RD_REQ: state_q <= S_RD_WAIT;
                S_RD_WAIT: begin
                    if (eng_done) begin
                        want_q  <= (eng_rdata & ~entry.mask) | (entry.value & entry.mask);
                        state_q <= S_WR_REQ;
                    end else if (eng_timeout) begin
                        state_q <= S_FAIL;
                    end
                end
                S_WR_REQ: state_q <= S_WR_WAIT;
                S_WR_WAIT: begin
                    if (eng_done) begin
                        if (VERIFY_EN) begin
                            state_q <= S_VR_REQ;
                        end else begin
                            idx_q   <= idx_q + 1'b1;
                            state_q <= S_FETCH;
                        end
                    end else if (eng_timeout) begin
                        state_q <= S_FAIL;
                    end
                end
                S_VR_REQ: state_q <= S_VR_WAIT;
                S_VR_WAIT: begin
                    if (eng_done) begin
                        if (eng_rdata == want_q) begin
                            idx_q   <= idx_q + 1'b1;
                            state_q <= S_FETCH;
                        end else begin
                            state_q <= S_FAIL;
                        end
                    end else if (eng_timeout) begin
                        state_q <= S_FAIL;
                    end
                end
                S_RST_HOLD: if (tmr_expired) state_q <= S_LOCK_WAIT;
                S_LOCK_WAIT: begin
                    if (&lock_i) begin
                        state_q <= S_DONE;
                    end else if (tmr_expired) begin
                        state_q <= S_FAIL;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign busy_o    = (state_q != S_IDLE);
    assign done_o    = (state_q == S_DONE);
    assign error_o   = (state_q == S_FAIL);
    assign pll_rst_o = (state_q == S_RST_HOLD);

endmodule

// File: rtl/rsq_checker.sv
// Protocol and sequencing checks for pll_rate_sequencer, bound to every
// instance. Watches only the top-level ports plus one pending-access flag.
module rsq_checker #(
    parameter int NUM_PLL = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic [2:0]         rate_i,
    input logic               busy_o,
    input logic               done_o,
    input logic               error_o,
    input logic [NUM_PLL-1:0] port_en_o,
    input logic [NUM_PLL-1:0] port_rdy_i,
    input logic               pll_rst_o,
    input logic [NUM_PLL-1:0] lock_i
);

    logic pend_q;

    // Tracks whether an issued access still waits for its ready.
    always_ff @(posedge clk) begin
        if (!rst_n)                     pend_q <= 1'b0;
        else if (|port_en_o)            pend_q <= 1'b1;
        else if (|port_rdy_i || error_o) pend_q <= 1'b0;
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!pll_rst_o && !(|port_en_o) && !done_o && !error_o));

    assert_no_access_in_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pll_rst_o |-> !(|port_en_o));

    assert_done_after_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(&lock_i));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_err_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && error_o));

    assert_bad_rate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && rate_i > 3'd4) |=> error_o);

    assert_one_enable_R14: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_en_o));

    assert_no_overlap_R14: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> !(|port_en_o));

endmodule

bind pll_rate_sequencer rsq_checker #(.NUM_PLL(NUM_PLL)) i_rsq_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .rate_i     (rate_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .error_o    (error_o),
    .port_en_o  (port_en_o),
    .port_rdy_i (port_rdy_i),
    .pll_rst_o  (pll_rst_o),
    .lock_i     (lock_i)
);

// File: tb/test_pll_rate_sequencer.sv
// Scoreboard bench: the driver queues each expected outcome, the monitor
// pops it on the done/error pulse; a PLL port model answers accesses.
module test_pll_rate_sequencer;

    localparam int NP       = 2;
    localparam int HOLD     = 40;
    localparam int LOCK_TO  = 300;
    localparam int LOCK_DLY = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [2:0]       rate_i = '0;
    logic             busy_o, done_o, error_o, pll_rst_o;
    logic [NP-1:0]    port_en_o, port_we_o, port_rdy_i, lock_i;
    logic [NP*9-1:0]  port_addr_o;
    logic [NP*16-1:0] port_wdata_o, port_rdata_i;

    always #5 clk = ~clk;

    pll_rate_sequencer #(
        .NUM_PLL(NP), .RESET_HOLD_CYC(HOLD), .LOCK_TIMEOUT_CYC(LOCK_TO),
        .ACK_TIMEOUT_CYC(1024), .VERIFY_EN(1'b1)
    ) i_pll_rate_sequencer (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rate_i(rate_i),
        .busy_o(busy_o), .done_o(done_o), .error_o(error_o),
        .port_en_o(port_en_o), .port_we_o(port_we_o), .port_addr_o(port_addr_o),
        .port_wdata_o(port_wdata_o), .port_rdata_i(port_rdata_i),
        .port_rdy_i(port_rdy_i), .pll_rst_o(pll_rst_o), .lock_i(lock_i)
    );

    // ---------------- PLL port model ----------------
    logic [15:0] mreg [NP][512];
    logic [1:0]  m_cnt [NP];
    logic        m_we  [NP];
    logic [8:0]  m_addr[NP];
    logic [15:0] m_wd  [NP];
    logic [15:0] m_rd  [NP];
    int          m_lcnt[NP];
    logic        preset_now = 1'b0, drop_rdy = 1'b0, corrupt = 1'b0;
    logic [NP-1:0] stuck = '0;

    function automatic logic cfg_good(input logic [15:0] n, input logic [15:0] r98);
        return (r98[6:5] == 2'b10) &&
               (n[7:0] == 8'h14 || n[7:0] == 8'h1E || n[7:0] == 8'h28 ||
                n[7:0] == 8'h32 || n[7:0] == 8'h3C);
    endfunction

    always_comb begin
        for (int p = 0; p < NP; p++) port_rdata_i[p*16 +: 16] = m_rd[p];
    end

    always @(posedge clk) begin
        for (int p = 0; p < NP; p++) begin
            port_rdy_i[p] <= 1'b0;
            if (preset_now) begin
                for (int a = 0; a < 512; a++) mreg[p][a] <= 16'h0000;
                mreg[p][9'h094] <= 16'hA528;
                mreg[p][9'h098] <= 16'h0820;
                mreg[p][9'h0A0] <= 16'h3055;
                m_cnt[p] <= '0;
                m_rd[p]  <= '0;
            end else if (port_en_o[p]) begin
                m_cnt[p]  <= 2'd2;
                m_we[p]   <= port_we_o[p];
                m_addr[p] <= port_addr_o[p*9 +: 9];
                m_wd[p]   <= port_wdata_o[p*16 +: 16];
            end else if (m_cnt[p] != 0) begin
                m_cnt[p] <= m_cnt[p] - 1'b1;
                if (m_cnt[p] == 2'd1 && !drop_rdy) begin
                    port_rdy_i[p] <= 1'b1;
                    if (m_we[p]) mreg[p][m_addr[p]] <= corrupt ? (m_wd[p] ^ 16'h8000) : m_wd[p];
                    else         m_rd[p] <= mreg[p][m_addr[p]];
                end
            end
            if (pll_rst_o || !rst_n) begin
                lock_i[p] <= 1'b0;
                m_lcnt[p] <= 0;
            end else if (!lock_i[p] && !stuck[p] &&
                         cfg_good(mreg[p][9'h094], mreg[p][9'h098])) begin
                m_lcnt[p] <= m_lcnt[p] + 1;
                if (m_lcnt[p] == LOCK_DLY) lock_i[p] <= 1'b1;
            end
        end
    end

    // ---------------- checking ----------------
    int vectors = 0, miscompares = 0;
    int exp_q[$];          // 0 = done expected, 1 = error expected
    int en_total = 0, wr_run = 0, rst_len = 0;
    int last_wr_pll = 0;
    logic order_bad = 1'b0, prev_rst = 1'b0, prev_done = 1'b0;

    task automatic check(input logic ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Monitor: result pulses, write order, reset width.
    always @(negedge clk) begin
        if (rst_n) begin
            if (start_i && !busy_o) begin
                wr_run = 0;
                order_bad = 1'b0;
                last_wr_pll = 0;
            end
            for (int p = 0; p < NP; p++) begin
                if (port_en_o[p]) en_total++;
                if (port_en_o[p] && port_we_o[p]) begin
                    wr_run++;
                    if (p < last_wr_pll) order_bad = 1'b1;
                    last_wr_pll = p;
                end
            end
            if (pll_rst_o && !prev_rst) begin
                check(wr_run == 3*NP && !order_bad, "R5 writes before reset", wr_run, 3*NP);
            end
            if (pll_rst_o) rst_len++;
            if (!pll_rst_o && prev_rst) begin
                check(rst_len == HOLD, "R6 reset width", rst_len, HOLD);
                rst_len = 0;
            end
            if (done_o || error_o) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected result pulse", int'(error_o), -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(int'(error_o) == e && (done_o != error_o), "R7/R11 outcome",
                          int'(error_o), e);
                end
            end
            if (done_o && prev_done) check(1'b0, "R7 done longer than one cycle", 1, 0);
            prev_rst  = pll_rst_o;
            prev_done = done_o;
        end
    end

    // Driver: queue expectation, pulse start, wait for the end.
    task automatic run(input logic [2:0] rate, input int expect_err, input bit overlap);
        exp_q.push_back(expect_err);
        @(negedge clk);
        start_i = 1'b1;
        rate_i  = rate;
        @(negedge clk);
        start_i = 1'b0;
        if (overlap) begin
            repeat (5) @(negedge clk);
            start_i = 1'b1;
            rate_i  = 3'd4;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (busy_o) @(negedge clk);
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R7 result pulse seen", exp_q.size(), 0);
    endtask

    task automatic preset();
        @(negedge clk);
        preset_now = 1'b1;
        @(negedge clk);
        preset_now = 1'b0;
    endtask

    initial begin
        int en_before;
        preset_now = 1'b1;
        repeat (3) @(negedge clk);
        preset_now = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !done_o && !error_o && !pll_rst_o && port_en_o == '0,
              "R1 reset state", {busy_o, done_o, error_o, pll_rst_o}, 0);

        // 12 Gb/s from the preset 8 Gb/s settings
        run(3'd4, 0, 1'b0);
        for (int p = 0; p < NP; p++) begin
            check(mreg[p][9'h094] == 16'hA53C, "R2/R3 divider at 12G", mreg[p][9'h094], 16'hA53C);
            check(mreg[p][9'h098] == 16'h0840, "R4 bits 6:5", mreg[p][9'h098], 16'h0840);
            check(mreg[p][9'h0A0] == 16'h3055, "R8 divider code 0", mreg[p][9'h0A0], 16'h3055);
        end

        // 4 Gb/s: output divider field set, other bits kept
        run(3'd0, 0, 1'b0);
        for (int p = 0; p < NP; p++) begin
            check(mreg[p][9'h094] == 16'hA514, "R3 divider at 4G", mreg[p][9'h094], 16'hA514);
            check(mreg[p][9'h0A0] == 16'h3155, "R8 divider code 1", mreg[p][9'h0A0], 16'h3155);
        end

        // 8 Gb/s with a second start while busy
        run(3'd2, 0, 1'b1);
        for (int p = 0; p < NP; p++)
            check(mreg[p][9'h094] == 16'hA528, "R9 start ignored while busy", mreg[p][9'h094], 16'hA528);

        // invalid rate code: error, no access
        en_before = en_total;
        run(3'd6, 1, 1'b0);
        check(en_total == en_before, "R10 no access on bad rate", en_total - en_before, 0);

        // PLL 1 never locks
        stuck = 2'b10;
        run(3'd3, 1, 1'b0);
        stuck = '0;

        // read-back mismatch
        corrupt = 1'b1;
        run(3'd1, 1, 1'b0);
        corrupt = 1'b0;
        preset();

        // port never ready
        drop_rdy = 1'b1;
        en_before = en_total;
        run(3'd2, 1, 1'b0);
        check(en_total - en_before == 1, "R12 requests stop after timeout", en_total - en_before, 1);
        drop_rdy = 1'b0;
        preset();

        // recovery at 6 Gb/s
        run(3'd1, 0, 1'b0);
        for (int p = 0; p < NP; p++)
            check(mreg[p][9'h094] == 16'hA51E, "R3/R13 divider at 6G", mreg[p][9'h094], 16'hA51E);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule